// File: doc/BRIEF.md
# I2C Master Receive Controller

This block is the receiving half of a bus master for a two-wire serial bus whose address phase is already done. It divides the system clock to make the serial clock. It shifts in one byte per frame from the slave and answers every frame with an acknowledge level that the host programs. Both bus lines are open-drain: the block only pulls a line low through its `*_oe` outputs, and reads the data line back through `sda_in`.

Received bytes leave on a valid/ready stream. `rx_valid` rises with a new byte and stays high, with `rx_data` frozen, until a cycle where `rx_ready` is also high. That handshake is the host's read of the data register.

The stream applies back-pressure to the bus. If a byte is still unread when the next frame reaches its acknowledge clock, the serial clock is held low until the handshake happens. A `rx_ready` pulse while idle, with `rx_valid` low and `rx_en` high, is the dummy read that starts reception. The `last_rx` level is sampled at every read, and when it is set the next frame ends with a stop condition.

Top module: `i2c_mrx_ctrl`

## Requirements
- R1: Out of reset both lines are released (`scl_oe` = 0, `sda_oe` = 0), and `rx_valid` and `stop_flag` are 0.
- R2: Reception begins only on a dummy read, meaning `rx_ready` high while `rx_valid` is low, the block is idle and `rx_en` is high. In the cycle after that read `scl_oe` is 1. A `rx_ready` pulse while `rx_en` is low, or no pulse at all, produces no clock.
- R3: Every SCL high phase lasts exactly `HI_CYC` cycles, and every SCL low phase lasts at least `LO_CYC` cycles.
- R4: Data are sampled on each rising SCL edge, most significant bit first. `sda_oe` is 0 during the eight data clocks.
- R5: During the 9th clock of a frame `sda_oe` equals the inverse of `ack_level`, so 0 gives ACK (line driven low) and 1 gives NACK (released). `ack_level` is sampled at the 8th falling edge.
- R6: `rx_valid` rises, and `rx_data` takes the new byte, in the same cycle that SCL rises for the 9th time.
- R7: A cycle with `rx_valid` and `rx_ready` both high clears `rx_valid` at that edge. While `rx_valid` is high, `rx_data` does not change.
- R8: If `rx_valid` is still high during the low phase before the 9th clock, SCL stays low. It rises on the second clock edge after the handshake edge.
- R9: `last_rx` is sampled at every read, the dummy read included. When it is 1, the frame that completes next is the final one, and no further SCL falling edge follows that frame's 9th clock.
- R10: After the final frame, SDA is driven low through one SCL low phase, then SCL is released for `HI_CYC` cycles, then SDA is released. `stop_flag` is set in the same cycle that SDA is released.
- R11: `stop_flag` stays set until the next dummy read, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive direction selected, with the transmit flags cleared |
| ack_level | input | 1 | Level for the 9th clock: 0 = ACK, 1 = NACK |
| last_rx | input | 1 | Marks the next completed frame as the last one |
| rx_ready | input | 1 | Host read strobe (stream ready) |
| rx_valid | output | 1 | Receive-full flag (stream valid) |
| rx_data | output | DW | Received byte |
| stop_flag | output | 1 | Stop condition has been issued |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The bench drives its inputs on falling clock edges and counts registers to decide in which cycle each result must be due.

- **Same cycle:** a new byte with `rx_valid`, checked in the sample where SCL first reads high for the 9th time; also `stop_flag` with the SDA release.
- **One edge after a strobe:** the start of SCL after a dummy read, and the clearing of `rx_valid` after a read. Both are checked in the sample immediately after the strobe.
- **Two edges after a late read:** the release of a stretched clock. It is checked low in the first sample and high in the second.

A monitor counts SCL high and low samples and the SDA hold before a stop, and compares them with `HI_CYC` and `LO_CYC`. The bench runs transfers of one to four frames with both acknowledge levels and three read latencies, one of them long enough to force stretching.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LOW     = 3'd1,
    PH_HIGH    = 3'd2,
    PH_STOP_LO = 3'd3,
    PH_STOP_HI = 3'd4
  } phase_e;
endpackage

// File: rtl/mrx_bus_seq.sv
module mrx_bus_seq
  import i2c_mrx_pkg::*;
#(
  parameter int LO_CYC = 5,
  parameter int HI_CYC = 4,
  parameter int FRAME  = 9,
  parameter int BIT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hold,
  input  logic             last_frame,
  input  logic             ack_level,
  output phase_e           state,
  output logic [BIT_W-1:0] bit_idx,
  output logic             rise_evt,
  output logic             stop_evt,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam int MAXC  = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LO_LD = CNT_W'(LO_CYC - 1);
  localparam logic [CNT_W-1:0] HI_LD = CNT_W'(HI_CYC - 1);
  localparam logic [BIT_W-1:0] ACK_BIT = BIT_W'(FRAME);
  localparam logic [BIT_W-1:0] PRE_ACK = BIT_W'(FRAME - 1);

  logic [CNT_W-1:0] cnt;
  logic             ack_q;
  logic             cnt_done;

  assign cnt_done = (cnt == '0);
  // Stretch: the ack clock cannot rise while the previous byte is unread.
  assign rise_evt = (state == PH_LOW) && cnt_done && !((bit_idx == ACK_BIT) && hold);
  assign stop_evt = (state == PH_STOP_HI) && cnt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      ack_q   <= 1'b0;
    end else begin
      unique case (state)
        PH_IDLE: begin
          if (start) begin
            state   <= PH_LOW;
            cnt     <= LO_LD;
            bit_idx <= BIT_W'(1);
          end
        end
        PH_LOW: begin
          if (!cnt_done) begin
            cnt <= cnt - CNT_W'(1);
          end else if (rise_evt) begin
            state <= PH_HIGH;
            cnt   <= HI_LD;
          end
        end
        PH_HIGH: begin
          if (!cnt_done) begin
            cnt <= cnt - CNT_W'(1);
          end else if (bit_idx == ACK_BIT) begin
            state <= last_frame ? PH_STOP_LO : PH_LOW;
            cnt   <= LO_LD;
            if (!last_frame) bit_idx <= BIT_W'(1);
          end else begin
            state   <= PH_LOW;
            cnt     <= LO_LD;
            bit_idx <= bit_idx + BIT_W'(1);
            if (bit_idx == PRE_ACK) ack_q <= ack_level;
          end
        end
        PH_STOP_LO: begin
          if (!cnt_done) begin
            cnt <= cnt - CNT_W'(1);
          end else begin
            state <= PH_STOP_HI;
            cnt   <= HI_LD;
          end
        end
        PH_STOP_HI: begin
          if (!cnt_done) cnt <= cnt - CNT_W'(1);
          else           state <= PH_IDLE;
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_oe = (state == PH_LOW) || (state == PH_STOP_LO);
    sda_oe = (state == PH_STOP_LO) || (state == PH_STOP_HI) ||
             (((state == PH_LOW) || (state == PH_HIGH)) && (bit_idx == ACK_BIT) && !ack_q);
  end

  // R2: without a start the sequencer remains idle
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_IDLE && !start) |=> (state == PH_IDLE));

  // R4: the bit counter stays in 1..FRAME while the bus is clocked
  p_bit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LOW || state == PH_HIGH) |-> (bit_idx >= BIT_W'(1) && bit_idx <= ACK_BIT));

  // R10: SDA does not move while SCL is high, except at the stop release
  p_sda_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && state != PH_IDLE) |-> $stable(sda_oe));
endmodule

// File: rtl/mrx_byte_buf.sv
module mrx_byte_buf #(
  parameter int DW    = 8,
  parameter int BIT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rise_evt,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             sda_in,
  input  logic             rx_ready,
  input  logic             last_rx,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  output logic             last_frame
);
  localparam logic [BIT_W-1:0] DATA_END = BIT_W'(DW);
  localparam logic [BIT_W-1:0] ACK_BIT  = BIT_W'(DW + 1);

  logic [DW-1:0] shreg;
  logic          fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      fin        <= 1'b0;
      last_frame <= 1'b0;
    end else begin
      if (rise_evt && bit_idx <= DATA_END) shreg <= {shreg[DW-2:0], sda_in};
      if (start) begin
        fin        <= last_rx;
        last_frame <= 1'b0;
      end else if (rise_evt && bit_idx == ACK_BIT) begin
        rx_data    <= shreg;
        rx_valid   <= 1'b1;
        last_frame <= fin;
        fin        <= 1'b0;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
        fin      <= last_rx;
      end
    end
  end

  // R7: an unread byte is never overwritten
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(rx_valid)) |-> $stable(rx_data));
endmodule

// File: rtl/i2c_mrx_ctrl.sv
module i2c_mrx_ctrl
  import i2c_mrx_pkg::*;
#(
  parameter int DW     = 8,
  parameter int LO_CYC = 5,
  parameter int HI_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          ack_level,
  input  logic          last_rx,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          stop_flag,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in
);
  localparam int FRAME = DW + 1;
  localparam int BIT_W = $clog2(FRAME + 1);

  phase_e           state;
  logic [BIT_W-1:0] bit_idx;
  logic             rise_evt, stop_evt, last_frame, start;

  assign start = rx_en && rx_ready && !rx_valid && (state == PH_IDLE);

  mrx_bus_seq #(
    .LO_CYC(LO_CYC), .HI_CYC(HI_CYC), .FRAME(FRAME), .BIT_W(BIT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .hold(rx_valid),
    .last_frame(last_frame), .ack_level(ack_level), .state(state),
    .bit_idx(bit_idx), .rise_evt(rise_evt), .stop_evt(stop_evt),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  mrx_byte_buf #(.DW(DW), .BIT_W(BIT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .start(start), .rise_evt(rise_evt),
    .bit_idx(bit_idx), .sda_in(sda_in), .rx_ready(rx_ready),
    .last_rx(last_rx), .rx_data(rx_data), .rx_valid(rx_valid),
    .last_frame(last_frame)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stop_flag <= 1'b0;
    else if (stop_evt) stop_flag <= 1'b1;
    else if (start)    stop_flag <= 1'b0;
  end

  // R6: a new byte appears together with the 9th rising SCL edge
  p_valid_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $fell(scl_oe));

  // R8: an unread byte keeps SCL low through the ack low phase
  p_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LOW && bit_idx == BIT_W'(FRAME) && rx_valid) |=> scl_oe);

  // R10: the stop flag rises exactly when SDA is let go with SCL high
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> (!sda_oe && !scl_oe && $past(sda_oe)));

  // R11: the flag only drops on a start
  p_flag_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_flag) |-> $past(start));
endmodule

// File: tb/i2c_mrx_ctrl_bench.sv
module i2c_mrx_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LO = 4;
  localparam int HI = 3;
  localparam int LONG_DLY = 90;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b0, ack_level = 1'b0, last_rx = 1'b0, rx_ready = 1'b0;
  logic rx_valid, stop_flag, scl_oe, sda_oe, sda_in;
  logic [7:0] rx_data;
  logic slave_bit = 1'b1;

  int checks = 0, errors = 0, cyc = 0;
  int rises = 0, base = 0, exp_frames = 0, cur_seed = 0;
  bit ack_exp = 1'b0, in_stop = 1'b0, hi_ok = 1'b0;
  bit prev_scl = 1'b0, prev_sda = 1'b0;
  int hi_run = 0, lo_run = 0, sdahi_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_in = slave_bit & ~sda_oe;

  i2c_mrx_ctrl #(.DW(8), .LO_CYC(LO), .HI_CYC(HI)) u_i2c_mrx_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ack_level(ack_level),
    .last_rx(last_rx), .rx_ready(rx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .stop_flag(stop_flag), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_in)
  );

  function automatic logic [7:0] eb(input int f);
    return 8'((f * 37 + 165 + cur_seed) % 256);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bus monitor and slave model, all on the falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      int rel, p;
      logic [7:0] b;
      rel = rises - base;
      if (prev_scl && !scl_oe) begin
        if (exp_frames > 0 && rel == 9 * exp_frames) begin
          chk(sda_oe == 1'b1, "R10 sda low at stop rise", sda_oe, 1);
          chk(lo_run >= LO, "R3 stop low phase", lo_run, LO);
          in_stop = 1'b1;
        end else begin
          p = rel % 9;
          if (p < 8) chk(sda_oe == 1'b0, "R4 sda released on data clock", sda_oe, 0);
          else       chk(sda_oe == !ack_exp, "R5 ack level on 9th clock", sda_oe, !ack_exp);
          chk(lo_run >= LO, "R3 low phase length", lo_run, LO);
          rises++;
          rel++;
          if (rel % 9 == 0) begin
            chk(rx_valid == 1'b1, "R6 valid at 9th rise", rx_valid, 1);
            chk(rx_data == eb(rel / 9 - 1), "R4 R6 byte at 9th rise", rx_data, eb(rel / 9 - 1));
          end
          hi_ok = 1'b1;
        end
      end
      if (!prev_scl && scl_oe) begin
        if (hi_ok) chk(hi_run == HI, "R3 high phase length", hi_run, HI);
        hi_ok = 1'b0;
        if (in_stop) chk(1'b0, "R9 extra SCL fall after final frame", 1, 0);
        p = rel % 9;
        b = eb(rel / 9);
        slave_bit = (p < 8) ? b[7-p] : 1'b1;
      end
      if (prev_sda && !sda_oe && !scl_oe) begin
        chk(stop_flag == 1'b1, "R10 flag with sda release", stop_flag, 1);
        chk(sdahi_run == HI, "R10 sda hold with scl high", sdahi_run, HI);
        chk(rel == 9 * exp_frames, "R9 clocks before stop", rel, 9 * exp_frames);
      end
      hi_run    = scl_oe ? 0 : hi_run + 1;
      lo_run    = scl_oe ? lo_run + 1 : 0;
      sdahi_run = (!scl_oe && sda_oe) ? sdahi_run + 1 : 0;
      prev_scl  = scl_oe;
      prev_sda  = sda_oe;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic pulse_read();
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
  endtask

  task automatic xfer(input int nfr, input bit ack, input int dly, input int seed);
    int t;
    ack_level = ack; ack_exp = ack; cur_seed = seed;
    last_rx = (nfr == 1);
    @(negedge clk);
    base = rises; exp_frames = nfr; in_stop = 1'b0; hi_ok = 1'b0;
    pulse_read();
    chk(scl_oe == 1'b1, "R2 SCL low after dummy read", scl_oe, 1);
    chk(stop_flag == 1'b0, "R11 flag cleared by start", stop_flag, 0);
    for (int f = 0; f < nfr; f++) begin
      t = 0;
      while (!rx_valid && t < 3000) begin @(negedge clk); t++; end
      chk(rx_valid == 1'b1, "R6 byte arrives", rx_valid, 1);
      chk(rx_data == eb(f), "R4 byte value", rx_data, eb(f));
      if (f < nfr - 1) begin
        repeat (dly) @(negedge clk);
        if (dly >= LONG_DLY) begin
          chk(scl_oe == 1'b1, "R8 SCL held low", scl_oe, 1);
          chk(rises - base == 9 * (f + 1) + 8, "R8 stretch point", rises - base, 9 * (f + 1) + 8);
        end
        if (f == nfr - 2) last_rx = 1'b1;
        pulse_read();
        chk(rx_valid == 1'b0, "R7 valid cleared by read", rx_valid, 0);
        if (dly >= LONG_DLY) begin
          chk(scl_oe == 1'b1, "R8 still low one edge after read", scl_oe, 1);
          @(negedge clk);
          chk(scl_oe == 1'b0, "R8 SCL rises two edges after read", scl_oe, 0);
        end
      end else begin
        t = 0;
        while (!stop_flag && t < 3000) begin @(negedge clk); t++; end
        chk(stop_flag == 1'b1, "R10 stop issued", stop_flag, 1);
        chk(rx_valid == 1'b1 && rx_data == eb(f), "R7 final byte kept", rx_data, eb(f));
        pulse_read();
        last_rx = 1'b0;
        chk(rx_valid == 1'b0, "R7 final read clears valid", rx_valid, 0);
        t = rises;
        repeat (20) @(negedge clk);
        chk(scl_oe == 1'b0 && rises == t, "R9 bus quiet after stop", rises - t, 0);
        chk(stop_flag == 1'b1, "R11 flag held", stop_flag, 1);
      end
    end
  endtask

  initial begin
    int r0, k;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !rx_valid && !stop_flag, "R1 reset state",
        {scl_oe, sda_oe, rx_valid, stop_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    r0 = rises;
    pulse_read();
    repeat (30) @(negedge clk);
    chk(scl_oe == 1'b0 && rises == r0, "R2 read ignored while disabled", scl_oe, 0);
    rx_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(scl_oe == 1'b0 && rises == r0, "R2 no clock without dummy read", scl_oe, 0);
    k = 0;
    for (int n = 1; n <= 4; n++) begin
      for (int a = 0; a < 2; a++) begin
        for (int d = 0; d < 3; d++) begin
          xfer(n, a[0], (d == 0) ? 0 : ((d == 1) ? 5 : LONG_DLY), k * 11);
          k++;
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule